// File: doc/BRIEF.md
# Track Format Write Byte Translator

This block sits between a host that streams bytes for a format (write-track) command and the bit encoder that puts them on the disk. The host answers each byte request with one byte. The block turns that byte into the byte that is actually written. In double density, one code value starts an address-mark sync run, and it is written as a sync byte with a missing clock. A second code value is never written as itself. In its place the block writes the two CRC bytes it has built up since the last preset. In single density the sync code is not recognised. Instead, the address-mark values are flagged so that the encoder writes them with their special clock pattern, and each one presets the CRC.

The block has four states:

- **IDLE**: no command is running.
- **ARM**: the command has started and the block waits for the first index pulse. It requests and holds the first byte while it waits.
- **DATA**: one host byte is translated on every byte-time strobe.
- **CRC_LO**: the second CRC byte is written and no host byte is requested.

The transitions are:

- IDLE→ARM on `start`.
- ARM→DATA on an index rising edge.
- DATA→CRC_LO when the CRC code is consumed.
- CRC_LO→DATA on the next strobe.
- DATA→IDLE and CRC_LO→IDLE on the second index rising edge.

If the host has not supplied a byte by the time a strobe arrives, the block writes a zero byte and latches a lost-data flag. The density is taken from `dd_mode` when the command starts and is held for the whole command.

Top module: `fmt_track_writer`

## Requirements
- R1: After reset `busy`, `host_req`, `out_valid` and `lost_data` are all 0.
- R2: A `start` pulse in IDLE raises `busy`, and `host_req` is then high while the one-byte holding register is empty. No byte is output before the first index rising edge, even if `byte_tick` pulses.
- R3: From the first index rising edge onward, each `byte_tick` causes exactly one `out_valid` pulse on the following cycle.
- R4: A host byte that is not a control code in the current density is written unchanged with `out_mark`=0. This covers FE and FB in double density, and F5 and F6 in single density.
- R5: In double density (`dd_mode`=1), host byte F5 is written as A1 with `out_mark`=1. The first F5 after any other written byte presets the CRC to FFFF before the A1 is folded in.
- R6: Host byte F7 is replaced by two CRC bytes, high byte first. The CRC is x^16+x^12+x^5+1, shifted MSB first, and covers every written byte since the last preset.
- R7: From the cycle after F7 is consumed until the low CRC byte is written, `host_req` stays 0.
- R8: In single density (`dd_mode`=0), host bytes FE, FB and F8 are written unchanged with `out_mark`=1. Each of them presets the CRC to FFFF before it is folded in.
- R9: If the holding register is empty at a strobe, 00 is written with `out_mark`=0 and folded into the CRC. `lost_data` is then set and stays set until the next accepted `start`.
- R10: The second index rising edge returns the block to IDLE. `busy` and `host_req` fall, and later strobes produce no output.
- R11: `start` while `busy` is ignored, and the byte stream continues unchanged.
- R12: `dd_mode` is sampled at an accepted `start`. Changing it during a command has no effect on how bytes are translated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a format command (accepted only in IDLE) |
| dd_mode | input | 1 | 1 = double density, 0 = single density |
| index_pulse | input | 1 | Index level from the drive; the rising edge is used |
| byte_tick | input | 1 | One-cycle strobe per disk byte time |
| host_req | output | 1 | Byte request to the host |
| host_valid | input | 1 | Host byte present this cycle |
| host_data | input | 8 | Host byte |
| out_valid | output | 1 | Written byte valid (one cycle) |
| out_byte | output | 8 | Byte to write |
| out_mark | output | 1 | Encoder must write this byte with its special clock pattern |
| busy | output | 1 | Command in progress |
| lost_data | output | 1 | Sticky host underrun flag |

## Verification
The double-density stream is a realistic ID field and data field: gap filler, a run of three sync codes, address marks, payload and two CRC codes. This shows that sync runs preset only once and that address marks pass through as plain data. The single-density stream mixes marks with F5 and F6 bytes. It tells the mark-and-preset path apart from the unrecognised sync code. A third stream starves the host for two byte times and then asks for a CRC, which shows that the filler zeros are folded in. That same run flips `dd_mode` and pulses `start` during the command, to confirm that both are ignored.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_DATA,
        ST_CRC_LO
    } fmt_state_e;

    typedef enum logic [1:0] {
        K_LIT,
        K_SYNC,
        K_CRC,
        K_MARK
    } byte_kind_e;

endpackage

// File: rtl/fmt_crc16.sv
module fmt_crc16 #(
    parameter int          CRC_W = 16,
    parameter int          DAT_W = 8,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [DAT_W-1:0] data_in,
    output logic [CRC_W-1:0] crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int k = DAT_W - 1; k >= 0; k--) begin
            if (c[CRC_W-1] ^ data_in[k]) c = {c[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
            else                         c = {c[CRC_W-2:0], 1'b0};
        end
        crc_out = c;
    end
endmodule

// File: rtl/fmt_xlat.sv
module fmt_xlat
    import fmt_pkg::*;
#(
    parameter int         DAT_W      = 8,
    parameter logic [7:0] CODE_SYNC  = 8'hF5,
    parameter logic [7:0] CODE_CRC   = 8'hF7,
    parameter logic [7:0] SYNC_BYTE  = 8'hA1,
    parameter logic [7:0] MARK_ID    = 8'hFE,
    parameter logic [7:0] MARK_DATA  = 8'hFB,
    parameter logic [7:0] MARK_DEL   = 8'hF8
) (
    input  logic             dd,
    input  logic [DAT_W-1:0] host_byte,
    output byte_kind_e       kind,
    output logic [DAT_W-1:0] wr_byte
);
    always_comb begin
        kind    = K_LIT;
        wr_byte = host_byte;
        if (host_byte == CODE_CRC[DAT_W-1:0]) begin
            kind = K_CRC;
        end else if (dd) begin
            if (host_byte == CODE_SYNC[DAT_W-1:0]) begin
                kind    = K_SYNC;
                wr_byte = SYNC_BYTE[DAT_W-1:0];
            end
        end else if (host_byte == MARK_ID[DAT_W-1:0] ||
                     host_byte == MARK_DATA[DAT_W-1:0] ||
                     host_byte == MARK_DEL[DAT_W-1:0]) begin
            kind = K_MARK;
        end
    end
endmodule

// File: rtl/fmt_edge.sv
module fmt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/fmt_track_writer.sv
module fmt_track_writer
    import fmt_pkg::*;
#(
    parameter int          DAT_W     = 8,
    parameter int          CRC_W     = 16,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF,
    parameter logic [7:0]  SYNC_BYTE = 8'hA1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dd_mode,
    input  logic             index_pulse,
    input  logic             byte_tick,
    output logic             host_req,
    input  logic             host_valid,
    input  logic [DAT_W-1:0] host_data,
    output logic             out_valid,
    output logic [DAT_W-1:0] out_byte,
    output logic             out_mark,
    output logic             busy,
    output logic             lost_data
);
    localparam int HALF = CRC_W / 2;

    fmt_state_e       st, st_nx;
    logic             dd_q;
    logic             hold_full;
    logic [DAT_W-1:0] hold_data;
    logic [CRC_W-1:0] crc_q;
    logic             prev_sync;

    logic             idx_rise;
    byte_kind_e       kind_raw, kind_eff;
    logic [DAT_W-1:0] wr_raw, wr_eff;
    logic [CRC_W-1:0] crc_base, crc_next;
    logic             under, consume, emit_lo, take, go_idle, accept;

    fmt_edge u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (index_pulse),
        .rise     (idx_rise)
    );

    fmt_xlat #(
        .DAT_W     (DAT_W),
        .SYNC_BYTE (SYNC_BYTE)
    ) u_xlat (
        .dd        (dd_q),
        .host_byte (hold_data),
        .kind      (kind_raw),
        .wr_byte   (wr_raw)
    );

    fmt_crc16 #(
        .CRC_W (CRC_W),
        .DAT_W (DAT_W),
        .POLY  (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_base),
        .data_in (wr_eff),
        .crc_out (crc_next)
    );

    // byte selection: an empty holding register writes a zero filler byte
    always_comb begin
        under    = ~hold_full;
        kind_eff = under ? K_LIT : kind_raw;
        wr_eff   = under ? '0 : wr_raw;
        if ((kind_eff == K_SYNC && !prev_sync) || kind_eff == K_MARK)
            crc_base = CRC_INIT[CRC_W-1:0];
        else
            crc_base = crc_q;
    end

    assign accept  = start && (st == ST_IDLE);
    assign consume = byte_tick && !idx_rise && (st == ST_DATA);
    assign emit_lo = byte_tick && !idx_rise && (st == ST_CRC_LO);
    assign go_idle = idx_rise && (st == ST_DATA || st == ST_CRC_LO);
    assign host_req = (st == ST_ARM || st == ST_DATA) && !hold_full;
    assign take    = host_req && host_valid;
    assign busy    = (st != ST_IDLE);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start)    st_nx = ST_ARM;
            ST_ARM:    if (idx_rise) st_nx = ST_DATA;
            ST_DATA: begin
                if (idx_rise)                          st_nx = ST_IDLE;
                else if (consume && kind_eff == K_CRC) st_nx = ST_CRC_LO;
            end
            ST_CRC_LO: begin
                if (idx_rise)       st_nx = ST_IDLE;
                else if (byte_tick) st_nx = ST_DATA;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dd_q      <= 1'b0;
            hold_full <= 1'b0;
            hold_data <= '0;
            crc_q     <= CRC_INIT[CRC_W-1:0];
            prev_sync <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_mark  <= 1'b0;
            lost_data <= 1'b0;
        end else begin
            out_valid <= consume || emit_lo;
            out_mark  <= 1'b0;

            if (accept) begin
                dd_q      <= dd_mode;
                lost_data <= 1'b0;
                crc_q     <= CRC_INIT[CRC_W-1:0];
                prev_sync <= 1'b0;
            end

            if (go_idle || accept)   hold_full <= 1'b0;
            else if (take)           hold_full <= 1'b1;
            else if (consume)        hold_full <= 1'b0;
            if (take)                hold_data <= host_data;

            if (consume) begin
                if (under) lost_data <= 1'b1;
                if (kind_eff == K_CRC) begin
                    out_byte  <= crc_q[CRC_W-1:HALF];
                    prev_sync <= 1'b0;
                end else begin
                    out_byte  <= wr_eff;
                    out_mark  <= (kind_eff == K_SYNC) || (kind_eff == K_MARK);
                    crc_q     <= crc_next;
                    prev_sync <= (kind_eff == K_SYNC);
                end
            end else if (emit_lo) begin
                out_byte  <= crc_q[HALF-1:0];
                prev_sync <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fmt_track_writer_chk.sv
module fmt_track_writer_chk #(
    parameter int         DAT_W     = 8,
    parameter logic [7:0] SYNC_BYTE = 8'hA1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             index_pulse,
    input logic             byte_tick,
    input logic             host_req,
    input logic             out_valid,
    input logic [DAT_W-1:0] out_byte,
    input logic             out_mark,
    input logic             busy,
    input logic             lost_data,
    input logic             dd_q
);
    // R3
    out_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(byte_tick));

    // R5
    dd_mark_is_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mark && dd_q) |-> out_byte == SYNC_BYTE[DAT_W-1:0]);

    // R8
    sd_mark_is_am_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mark && !dd_q) |-> (out_byte == 8'hFE || out_byte == 8'hFB || out_byte == 8'hF8));

    // R9
    lost_writes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_data) |-> (out_valid && out_byte == '0 && !out_mark));

    // R10
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !host_req));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !index_pulse) |=> busy);
endmodule

bind fmt_track_writer fmt_track_writer_chk #(
    .DAT_W     (DAT_W),
    .SYNC_BYTE (SYNC_BYTE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .index_pulse (index_pulse),
    .byte_tick   (byte_tick),
    .host_req    (host_req),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .out_mark    (out_mark),
    .busy        (busy),
    .lost_data   (lost_data),
    .dd_q        (dd_q)
);

// File: tb/fmt_track_writer_tb.sv
module fmt_track_writer_tb;

    typedef struct {
        logic [7:0] b;
        logic       m;
        int         tag;   // 0 plain, 1 CRC high, 2 CRC low
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dd_mode = 1'b1;
    logic       index_pulse = 1'b0;
    logic       byte_tick = 1'b0;
    logic       host_valid = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_req, out_valid, out_mark, busy, lost_data;
    logic [7:0] out_byte;

    item_t      exp_q[$];
    logic [7:0] feed_q[$];
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    int         pend = 0;
    bit         in_crc = 0;
    bit         done = 0;
    logic [15:0] m_crc;
    bit         m_sync, m_dd;

    always #10 clk = ~clk;

    fmt_track_writer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dd_mode(dd_mode),
        .index_pulse(index_pulse), .byte_tick(byte_tick),
        .host_req(host_req), .host_valid(host_valid), .host_data(host_data),
        .out_valid(out_valid), .out_byte(out_byte), .out_mark(out_mark),
        .busy(busy), .lost_data(lost_data)
    );

    task automatic chk(string r, string what, int act, int ex);
        checks++;
        if (act != ex) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, ex);
        end
    endtask

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] d);
        for (int k = 7; k >= 0; k--)
            c = (c[15] ^ d[k]) ? ((c << 1) ^ 16'h1021) : (c << 1);
        return c;
    endfunction

    function automatic void push_exp(logic [7:0] b, logic m, int tag, string r);
        item_t it;
        it.b = b; it.m = m; it.tag = tag; it.req = r;
        exp_q.push_back(it);
        pend++;
    endfunction

    // scoreboard driver: model the translation and queue the host byte
    task automatic host(logic [7:0] b);
        if (b == 8'hF7) begin
            push_exp(m_crc[15:8], 1'b0, 1, "R6");
            push_exp(m_crc[7:0], 1'b0, 2, "R6");
            m_sync = 0;
        end else if (m_dd && b == 8'hF5) begin
            if (!m_sync) m_crc = 16'hFFFF;
            m_crc = crc_step(m_crc, 8'hA1);
            push_exp(8'hA1, 1'b1, 0, "R5");
            m_sync = 1;
        end else if (!m_dd && (b == 8'hFE || b == 8'hFB || b == 8'hF8)) begin
            m_crc = crc_step(16'hFFFF, b);
            push_exp(b, 1'b1, 0, "R8");
            m_sync = 0;
        end else begin
            m_crc = crc_step(m_crc, b);
            push_exp(b, 1'b0, 0, "R4");
            m_sync = 0;
        end
        feed_q.push_back(b);
    endtask

    task automatic expect_lost();
        m_crc = crc_step(m_crc, 8'h00);
        push_exp(8'h00, 1'b0, 0, "R9");
        m_sync = 0;
    endtask

    task automatic cmd_begin(bit dd);
        @(negedge clk);
        dd_mode = dd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_dd = dd; m_crc = 16'hFFFF; m_sync = 0; pend = 0;
    endtask

    task automatic tick();
        @(negedge clk); byte_tick = 1'b1;
        @(negedge clk); byte_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_pending();
        int n;
        n = pend;
        pend = 0;
        for (int i = 0; i < n; i++) tick();
        repeat (2) @(negedge clk);
    endtask

    task automatic index();
        @(negedge clk); index_pulse = 1'b1;
        @(negedge clk); index_pulse = 1'b0;
        @(negedge clk);
    endtask

    // host feeder
    always @(negedge clk) begin
        if (host_req && feed_q.size() > 0) begin
            host_data  <= feed_q.pop_front();
            host_valid <= 1'b1;
        end else begin
            host_valid <= 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        cyc++;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10", "unexpected output byte", int'(out_byte), -1);
            end else begin
                it = exp_q.pop_front();
                chk(it.req, "written byte", int'({out_mark, out_byte}), int'({it.m, it.b}));
                if (it.tag == 1) in_crc = 1;
                if (it.tag == 2) in_crc = 0;
            end
        end
        if (in_crc) chk("R7", "host_req during CRC", int'(host_req), 0);
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "host_req", int'(host_req), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "lost_data", int'(lost_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Double density: ID field and data field
        cmd_begin(1'b1);
        chk("R2", "busy after start", int'(busy), 1);
        chk("R2", "host_req while armed", int'(host_req), 1);
        for (int i = 0; i < 3; i++) host(8'h4E);
        host(8'h00); host(8'h00);
        for (int i = 0; i < 3; i++) host(8'hF5);
        host(8'hFE); host(8'h05); host(8'h00); host(8'h07); host(8'h01); host(8'hF7);
        host(8'h4E); host(8'h4E);
        for (int i = 0; i < 3; i++) host(8'hF5);
        host(8'hFB); host(8'h12); host(8'h34); host(8'hF7); host(8'h4E);
        tick();   // before the index: must produce nothing
        chk("R2", "pending items before index", exp_q.size(), 26);
        index();
        run_pending();
        chk("R3", "items left after stream", exp_q.size(), 0);
        chk("R9", "lost_data with timely host", int'(lost_data), 0);
        index();
        chk("R10", "busy after second index", int'(busy), 0);
        chk("R10", "host_req after second index", int'(host_req), 0);
        tick();

        // Single density: marks, plain F5/F6, CRC
        cmd_begin(1'b0);
        host(8'hFF); host(8'h00); host(8'hFE); host(8'h01); host(8'h00);
        host(8'h03); host(8'h01); host(8'hF7); host(8'hF5); host(8'hF6);
        host(8'hF8); host(8'hAA); host(8'hF7); host(8'hFB); host(8'h55); host(8'hF7);
        index();
        run_pending();
        chk("R3", "items left after SD stream", exp_q.size(), 0);
        index();
        chk("R10", "busy after SD command", int'(busy), 0);

        // Underrun with density flip and stray start mid-command
        cmd_begin(1'b1);
        dd_mode = 1'b0;                      // R12: must be ignored
        host(8'h4E); host(8'hF5); host(8'h42);
        index();
        run_pending();
        @(negedge clk); start = 1'b1;        // R11: must be ignored
        @(negedge clk); start = 1'b0;
        chk("R11", "busy after stray start", int'(busy), 1);
        expect_lost(); expect_lost();
        run_pending();
        chk("R9", "lost_data after underrun", int'(lost_data), 1);
        host(8'hF7);
        run_pending();
        chk("R12", "items left after flipped mode", exp_q.size(), 0);
        chk("R9", "lost_data still set", int'(lost_data), 1);
        index();
        cmd_begin(1'b1);
        chk("R9", "lost_data cleared by start", int'(lost_data), 0);
        index();
        index();
        chk("R10", "idle at end", int'(busy), 0);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule